// File: doc/BRIEF.md
# Interrupt Redirection and Destination Selector

This block sits between a bank of interrupt input pins and the fabric that carries interrupt messages to processor-local units. Each pin has a redirection entry with a vector, a delivery mode, a destination mode, a polarity, a trigger bit, a mask bit and a destination byte. A low-to-high transition on a pin whose entry is unmasked marks that pin pending. Pending pins are served one per cycle, lowest pin number first. Each one becomes a single-cycle message on the output that carries the entry's attributes and a bitmask naming which of the N local units must receive it.

Targets come from the destination mode. In physical mode the destination byte names one unit by ID (unit i has ID i), and 0xFF names all units. In logical mode, every unit whose logical-destination byte shares a set bit with the entry's destination byte is a target. Lowest-priority delivery in logical mode narrows the matched set to one unit, using a rotating counter. Lowest-priority delivery in physical mode is rejected with an error pulse. External-interrupt delivery takes its vector from a separate controller input rather than from the entry.

Top module: `irq_route_top`

## Requirements
- R1: A message is raised only by a pin going from low to high, as seen at a rising clock edge against the pin's stored state. A pin held high raises nothing more. Driving a pin low only clears its stored state.
- R2: An entry whose mask bit (bit 22 of the 23-bit entry) is set at the edge where its pin rises produces no message and leaves nothing pending. The pin's stored state is still set, so clearing the mask while the pin stays high produces no message.
- R3: The message vector is `extVector` when the delivery-mode field (bits 18:16) equals 7 (external). Otherwise it is the entry's vector field (bits 7:0). The delivery mode, the destination-mode bit (bit 19), polarity (bit 20) and trigger (bit 21) are copied to the message.
- R4: In physical mode (bit 19 = 0), a destination byte (bits 15:8) of 0xFF targets all N units, and any other value targets only the unit with that ID. If no such unit exists, the target set is empty.
- R5: Lowest-priority delivery (mode 1) in physical mode produces no message and a one-cycle `errLowPhys` pulse in the cycle where the message would have appeared.
- R6: In logical mode (bit 19 = 1), unit i is a target when the bitwise AND of its logical byte (`unitLogical[8i+7:8i]`) and the destination byte is nonzero.
- R7: In lowest-priority logical mode with k > 0 matches, exactly one unit is targeted: the matched unit at position (counter mod k), counting matches in ascending ID order.
- R8: The rotation counter is 8 bits wide, wraps, and is zero after reset. It advances by one only when a lowest-priority logical selection is made.
- R9: Pins that become pending together are served one per cycle, in ascending pin number. The others stay pending until served.
- R10: A pin rising before clock edge k yields `msgValid` for exactly the cycle after edge k+1 (if it is first in line). All outputs are zero after reset, and a message whose target set is empty is not sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | NPINS | Interrupt input pins |
| tableFlat | input | NPINS*23 | Redirection entries, entry p at bits [23p+22:23p] |
| extVector | input | 8 | Vector supplied by the external interrupt controller |
| unitLogical | input | NUNITS*8 | Logical-destination byte of each local unit |
| msgValid | output | 1 | One-cycle message strobe |
| msgVector | output | 8 | Message vector |
| msgDelivMode | output | 3 | Message delivery mode |
| msgDestLogical | output | 1 | Message destination mode (1 = logical) |
| msgLevel | output | 1 | Message level (entry polarity) |
| msgTrigger | output | 1 | Message trigger bit |
| msgTargets | output | NUNITS | Bitmask of receiving units |
| errLowPhys | output | 1 | Pulse for lowest-priority delivery requested in physical mode |

## Verification
The bench targets pins held high or raised while masked and then unmasked. A design that detects levels instead of edges, or keeps masked edges pending, would send extra messages in those cases. It raises several pins in one cycle to check that none is lost and that they come out in ascending order, and it looks for a physical destination outside the unit range where a design might wrap the ID to a real unit. Lowest-priority rounds are interleaved with empty matches and physical-mode rejects. A counter that advances on those would pick the wrong unit in the next round, and a wrong modulo or ordering would break the expected 0, 1, 3, 0 rotation over a three-unit set.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam logic [2:0] DM_FIXED  = 3'd0;
  localparam logic [2:0] DM_LOWPRI = 3'd1;
  localparam logic [2:0] DM_EXTINT = 3'd7;

  typedef struct packed {
    logic       mask;
    logic       trigger;
    logic       polarity;
    logic       destLogical;
    logic [2:0] delivMode;
    logic [7:0] dest;
    logic [7:0] vector;
  } redir_entry_t;

  localparam int ENTRY_W = $bits(redir_entry_t);

  // control -> datapath strobes
  typedef struct packed {
    logic       serve;
    logic [7:0] pinIdx;
  } ctl_strobe_t;

endpackage

// File: rtl/irq_pin_ctl.sv
module irq_pin_ctl
  import irq_route_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NPINS-1:0] pinIn,
  input  logic [NPINS-1:0] pinMask,
  output ctl_strobe_t      strobe
);

  logic [NPINS-1:0] pinState;
  logic [NPINS-1:0] pending;
  logic [NPINS-1:0] riseVec;
  logic [NPINS-1:0] serveOneHot;

  assign riseVec = pinIn & ~pinState;

  // lowest pending pin wins: scan downward so the last hit is the lowest
  always_comb begin
    serveOneHot = '0;
    strobe      = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (pending[i]) begin
        serveOneHot    = '0;
        serveOneHot[i] = 1'b1;
        strobe.serve   = 1'b1;
        strobe.pinIdx  = 8'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinState <= '0;
      pending  <= '0;
    end else begin
      pinState <= pinIn;
      pending  <= (pending & ~serveOneHot) | (riseVec & ~pinMask);
    end
  end

endmodule

// File: rtl/irq_nth_pick.sv
module irq_nth_pick #(
  parameter int NUNITS = 4,
  parameter int CNT_W  = 8
) (
  input  logic [NUNITS-1:0] matchVec,
  input  logic [CNT_W-1:0]  rotCount,
  output logic [NUNITS-1:0] pickVec
);

  always_comb begin
    int total;
    int pos;
    int rank;
    total = 0;
    for (int i = 0; i < NUNITS; i++) begin
      if (matchVec[i]) total = total + 1;
    end
    pos  = (total == 0) ? 0 : (int'(rotCount) % total);
    rank = 0;
    pickVec = '0;
    for (int i = 0; i < NUNITS; i++) begin
      if (matchVec[i]) begin
        if (rank == pos) pickVec[i] = 1'b1;
        rank = rank + 1;
      end
    end
  end

endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int NPINS  = 24,
  parameter int NUNITS = 4,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctl_strobe_t              strobe,
  input  logic [NPINS*ENTRY_W-1:0] tableFlat,
  input  logic [7:0]               extVector,
  input  logic [NUNITS*8-1:0]      unitLogical,
  output logic                     msgValid,
  output logic [7:0]               msgVector,
  output logic [2:0]               msgDelivMode,
  output logic                     msgDestLogical,
  output logic                     msgLevel,
  output logic                     msgTrigger,
  output logic [NUNITS-1:0]        msgTargets,
  output logic                     errLowPhys
);

  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;

  redir_entry_t tbl [NPINS];
  redir_entry_t cur;
  logic [NUNITS-1:0] logicMatch, physMatch, lpPick, targets;
  logic [CNT_W-1:0]  rotCount;
  logic isLowPri, sendNext, errNext, lpAdvance;

  for (genvar g = 0; g < NPINS; g++) begin : g_unpack
    assign tbl[g] = redir_entry_t'(tableFlat[g*ENTRY_W +: ENTRY_W]);
  end

  assign cur      = tbl[strobe.pinIdx[IDX_W-1:0]];
  assign isLowPri = (cur.delivMode == DM_LOWPRI);

  for (genvar u = 0; u < NUNITS; u++) begin : g_unit
    assign logicMatch[u] = |(unitLogical[u*8 +: 8] & cur.dest);
    assign physMatch[u]  = (cur.dest == 8'hFF) || (cur.dest == 8'(u));
  end

  irq_nth_pick #(.NUNITS(NUNITS), .CNT_W(CNT_W)) i_pick (
    .matchVec (logicMatch),
    .rotCount (rotCount),
    .pickVec  (lpPick)
  );

  always_comb begin
    if (cur.destLogical) targets = isLowPri ? lpPick : logicMatch;
    else                 targets = physMatch;
  end

  assign errNext   = strobe.serve && isLowPri && !cur.destLogical;
  assign sendNext  = strobe.serve && !errNext && (|targets);
  assign lpAdvance = strobe.serve && isLowPri && cur.destLogical && (|logicMatch);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rotCount       <= '0;
      msgValid       <= 1'b0;
      msgVector      <= '0;
      msgDelivMode   <= '0;
      msgDestLogical <= 1'b0;
      msgLevel       <= 1'b0;
      msgTrigger     <= 1'b0;
      msgTargets     <= '0;
      errLowPhys     <= 1'b0;
    end else begin
      if (lpAdvance) rotCount <= rotCount + 1'b1;
      msgValid   <= sendNext;
      errLowPhys <= errNext;
      if (sendNext) begin
        msgVector      <= (cur.delivMode == DM_EXTINT) ? extVector : cur.vector;
        msgDelivMode   <= cur.delivMode;
        msgDestLogical <= cur.destLogical;
        msgLevel       <= cur.polarity;
        msgTrigger     <= cur.trigger;
        msgTargets     <= targets;
      end
    end
  end

endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
#(
  parameter int NPINS  = 24,
  parameter int NUNITS = 4,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NPINS-1:0]         pinIn,
  input  logic [NPINS*ENTRY_W-1:0] tableFlat,
  input  logic [7:0]               extVector,
  input  logic [NUNITS*8-1:0]      unitLogical,
  output logic                     msgValid,
  output logic [7:0]               msgVector,
  output logic [2:0]               msgDelivMode,
  output logic                     msgDestLogical,
  output logic                     msgLevel,
  output logic                     msgTrigger,
  output logic [NUNITS-1:0]        msgTargets,
  output logic                     errLowPhys
);

  logic [NPINS-1:0] pinMask;
  ctl_strobe_t      strobe;

  for (genvar g = 0; g < NPINS; g++) begin : g_mask
    assign pinMask[g] = tableFlat[g*ENTRY_W + ENTRY_W - 1];
  end

  irq_pin_ctl #(.NPINS(NPINS)) i_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .pinMask (pinMask),
    .strobe  (strobe)
  );

  irq_route_dp #(.NPINS(NPINS), .NUNITS(NUNITS), .CNT_W(CNT_W)) i_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .tableFlat      (tableFlat),
    .extVector      (extVector),
    .unitLogical    (unitLogical),
    .msgValid       (msgValid),
    .msgVector      (msgVector),
    .msgDelivMode   (msgDelivMode),
    .msgDestLogical (msgDestLogical),
    .msgLevel       (msgLevel),
    .msgTrigger     (msgTrigger),
    .msgTargets     (msgTargets),
    .errLowPhys     (errLowPhys)
  );

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NUNITS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        extVector,
  input logic              msgValid,
  input logic [7:0]        msgVector,
  input logic [2:0]        msgDelivMode,
  input logic              msgDestLogical,
  input logic [NUNITS-1:0] msgTargets,
  input logic              errLowPhys
);

  assert_empty_not_sent_R10: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (msgTargets != '0));

  assert_lp_single_target_R7: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgDelivMode == 3'd1) |-> ($countones(msgTargets) == 1));

  assert_no_lp_physical_R5: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> !(msgDelivMode == 3'd1 && !msgDestLogical));

  assert_err_excludes_msg_R5: assert property (@(posedge clk) disable iff (!rstN)
    errLowPhys |-> !msgValid);

  assert_ext_vector_R3: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgDelivMode == 3'd7) |-> (msgVector == $past(extVector)));

  assert_phys_shape_R4: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgDestLogical) |-> ($countones(msgTargets) == 1 || (&msgTargets)));

endmodule

bind irq_route_top irq_route_chk #(.NUNITS(NUNITS)) i_chk (
  .clk            (clk),
  .rstN           (rstN),
  .extVector      (extVector),
  .msgValid       (msgValid),
  .msgVector      (msgVector),
  .msgDelivMode   (msgDelivMode),
  .msgDestLogical (msgDestLogical),
  .msgTargets     (msgTargets),
  .errLowPhys     (errLowPhys)
);

// File: tb/test_irq_route_top.sv
module test_irq_route_top;

  localparam int NP = 24;
  localparam int NU = 4;
  localparam int EW = 23;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0] pinIn = '0;
  logic [NP*EW-1:0] tableFlat;
  logic [7:0] extVector = 8'h00;
  logic [NU*8-1:0] unitLogical;
  logic msgValid, msgDestLogical, msgLevel, msgTrigger, errLowPhys;
  logic [7:0] msgVector;
  logic [2:0] msgDelivMode;
  logic [NU-1:0] msgTargets;

  logic [EW-1:0] ent [NP];
  logic [7:0] unitLog [NU];

  int checks = 0;
  int errors = 0;

  // model state
  logic [NP-1:0] mPin = '0;
  logic [NP-1:0] mPend = '0;
  logic [7:0] mCnt = 8'd0;

  always #5 clk = ~clk;

  always_comb begin
    for (int p = 0; p < NP; p++) tableFlat[p*EW +: EW] = ent[p];
    for (int u = 0; u < NU; u++) unitLogical[u*8 +: 8] = unitLog[u];
  end

  irq_route_top i_irq_route_top (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .tableFlat(tableFlat),
    .extVector(extVector), .unitLogical(unitLogical), .msgValid(msgValid),
    .msgVector(msgVector), .msgDelivMode(msgDelivMode),
    .msgDestLogical(msgDestLogical), .msgLevel(msgLevel),
    .msgTrigger(msgTrigger), .msgTargets(msgTargets), .errLowPhys(errLowPhys)
  );

  function automatic logic [EW-1:0] mkEnt(bit msk, bit trg, bit pol, bit lgc,
                                          logic [2:0] mode, logic [7:0] dst,
                                          logic [7:0] vec);
    return {msk, trg, pol, lgc, mode, dst, vec};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: model predicts, design runs, compare at the following negedge
  task automatic step(string tag);
    logic [NP-1:0] served;
    logic [NU-1:0] expT, match;
    logic [EW-1:0] e;
    logic [7:0] expVec, nextCnt;
    bit expV, expE, isLp, lgc;
    int idx, k, pos, rank;
    served = '0; expT = '0; expV = 0; expE = 0; expVec = 0; e = '0;
    nextCnt = mCnt; idx = -1;
    for (int p = NP - 1; p >= 0; p--) if (mPend[p]) idx = p;
    if (idx >= 0) begin
      served[idx] = 1'b1;
      e = ent[idx];
      isLp = (e[18:16] == 3'd1);
      lgc = e[19];
      expVec = (e[18:16] == 3'd7) ? extVector : e[7:0];
      if (isLp && !lgc) expE = 1;
      else if (!lgc) begin
        for (int u = 0; u < NU; u++)
          expT[u] = (e[15:8] == 8'hFF) || (e[15:8] == 8'(u));
      end else begin
        k = 0;
        for (int u = 0; u < NU; u++) begin
          match[u] = (unitLog[u] & e[15:8]) != 0;
          if (match[u]) k++;
        end
        if (isLp) begin
          if (k > 0) begin
            pos = int'(mCnt) % k; rank = 0;
            for (int u = 0; u < NU; u++)
              if (match[u]) begin
                if (rank == pos) expT[u] = 1'b1;
                rank++;
              end
            nextCnt = mCnt + 8'd1;
          end
        end else expT = match;
      end
      expV = !expE && (expT != 0);
    end
    mPend = (mPend & ~served);
    for (int p = 0; p < NP; p++)
      if (pinIn[p] && !mPin[p] && !ent[p][22]) mPend[p] = 1'b1;
    mPin = pinIn;
    mCnt = nextCnt;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " valid"}, 32'(msgValid), 32'(expV));
    chk({tag, " err"}, 32'(errLowPhys), 32'(expE));
    if (expV) begin
      chk({tag, " vector"}, 32'(msgVector), 32'(expVec));
      chk({tag, " fields"}, {27'd0, msgTrigger, msgLevel, msgDestLogical, msgDelivMode},
          {27'd0, e[21], e[20], e[19], e[18:16]});
      chk({tag, " targets"}, 32'(msgTargets), 32'(expT));
    end
  endtask

  // raise a pin, let it be served, drop it; report what the message showed
  task automatic pulse(int p, string tag, output logic v, output logic [7:0] vec,
                       output logic [NU-1:0] t, output logic er);
    pinIn[p] = 1'b1;
    step(tag);
    step(tag);
    v = msgValid; vec = msgVector; t = msgTargets; er = errLowPhys;
    pinIn[p] = 1'b0;
    step(tag);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic v, er;
    logic [7:0] vec;
    logic [NU-1:0] t;
    void'($urandom(32'd20240917));
    for (int p = 0; p < NP; p++) ent[p] = mkEnt(1, 0, 0, 0, 3'd0, 8'd0, 8'd0);
    unitLog[0] = 8'h01; unitLog[1] = 8'h02; unitLog[2] = 8'h04; unitLog[3] = 8'h03;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8 / R10: reset state of the outputs
    chk("R10 reset valid", 32'(msgValid), 0);
    chk("R8 reset err", 32'(errLowPhys), 0);
    chk("R10 reset targets", 32'(msgTargets), 0);

    // R1: edge only; held high gives nothing more
    ent[0] = mkEnt(0, 1, 1, 0, 3'd0, 8'd2, 8'h41);
    pinIn[0] = 1'b1;
    step("R1 edge");
    chk("R10 no output one edge after rise", 32'(msgValid), 0);
    step("R1 msg");
    chk("R1 first message", 32'(msgValid), 1);
    chk("R4 physical single", 32'(msgTargets), 32'h4);
    repeat (4) step("R1 held high");
    chk("R1 no repeat while high", 32'(msgValid), 0);
    pinIn[0] = 1'b0; step("R1 low");
    pulse(0, "R1 second edge", v, vec, t, er);
    chk("R1 re-raise fires", 32'(v), 1);

    // R2: masked at the edge, unmasked while high
    ent[1] = mkEnt(1, 0, 0, 0, 3'd0, 8'd1, 8'h51);
    pinIn[1] = 1'b1;
    repeat (3) step("R2 masked");
    chk("R2 masked edge silent", 32'(msgValid), 0);
    ent[1][22] = 1'b0;
    repeat (3) step("R2 unmasked high");
    chk("R2 no late message", 32'(msgValid), 0);
    pinIn[1] = 1'b0; step("R2 low");
    pulse(1, "R2 fresh edge", v, vec, t, er);
    chk("R2 fresh edge fires", 32'(v), 1);

    // R3: external vector versus entry vector
    extVector = 8'h99;
    ent[2] = mkEnt(0, 0, 1, 0, 3'd7, 8'd0, 8'h10);
    pulse(2, "R3 ext", v, vec, t, er);
    chk("R3 external vector", 32'(vec), 32'h99);
    ent[2] = mkEnt(0, 1, 0, 0, 3'd4, 8'd0, 8'h10);
    pulse(2, "R3 nmi", v, vec, t, er);
    chk("R3 entry vector", 32'(vec), 32'h10);

    // R4: broadcast, out-of-range ID, in-range ID
    ent[6] = mkEnt(0, 0, 0, 0, 3'd0, 8'hFF, 8'h60);
    pulse(6, "R4 broadcast", v, vec, t, er);
    chk("R4 broadcast all", 32'(t), 32'hF);
    ent[6] = mkEnt(0, 0, 0, 0, 3'd0, 8'd7, 8'h61);
    pulse(6, "R4 no such unit", v, vec, t, er);
    chk("R4 out of range silent", 32'(v), 0);
    ent[6] = mkEnt(0, 0, 0, 0, 3'd0, 8'd3, 8'h62);
    pulse(6, "R4 id3", v, vec, t, er);
    chk("R4 unit3", 32'(t), 32'h8);

    // R5: lowest priority in physical mode
    ent[7] = mkEnt(0, 0, 0, 0, 3'd1, 8'd1, 8'h70);
    pulse(7, "R5 lp phys", v, vec, t, er);
    chk("R5 error pulse", 32'(er), 1);
    chk("R5 no message", 32'(v), 0);

    // R6: logical AND match
    ent[8] = mkEnt(0, 0, 0, 1, 3'd0, 8'h02, 8'h80);
    pulse(8, "R6 logical", v, vec, t, er);
    chk("R6 units 1 and 3", 32'(t), 32'hA);
    // R10: empty logical match is not sent
    ent[8] = mkEnt(0, 0, 0, 1, 3'd0, 8'h80, 8'h81);
    pulse(8, "R10 empty", v, vec, t, er);
    chk("R10 empty match silent", 32'(v), 0);

    // R8: empty lowest-priority match does not advance the counter
    ent[9] = mkEnt(0, 0, 0, 1, 3'd1, 8'h80, 8'h90);
    pulse(9, "R8 lp empty", v, vec, t, er);
    chk("R8 empty lp silent", 32'(v), 0);
    // R7: rotation over units {0,1,3}
    ent[9] = mkEnt(0, 0, 0, 1, 3'd1, 8'h03, 8'h91);
    pulse(9, "R7 lp", v, vec, t, er);
    chk("R7 pick 0 (R8 counter at zero)", 32'(t), 32'h1);
    pulse(9, "R7 lp", v, vec, t, er);
    chk("R7 pick 1", 32'(t), 32'h2);
    pulse(9, "R7 lp", v, vec, t, er);
    chk("R7 pick 3", 32'(t), 32'h8);
    pulse(7, "R8 phys lp between", v, vec, t, er);
    pulse(9, "R7 lp", v, vec, t, er);
    chk("R7 wrap to 0", 32'(t), 32'h1);

    // R9: simultaneous rises served in ascending order
    ent[3] = mkEnt(0, 0, 0, 0, 3'd0, 8'd0, 8'h33);
    ent[4] = mkEnt(0, 0, 0, 0, 3'd0, 8'd0, 8'h44);
    ent[5] = mkEnt(0, 0, 0, 0, 3'd0, 8'd0, 8'h55);
    pinIn[5] = 1'b1; pinIn[3] = 1'b1; pinIn[4] = 1'b1;
    step("R9 rise");
    step("R9 first");
    chk("R9 pin3 first", 32'(msgVector), 32'h33);
    step("R9 second");
    chk("R9 pin4 second", 32'(msgVector), 32'h44);
    step("R9 third");
    chk("R9 pin5 third", 32'(msgVector), 32'h55);
    pinIn = '0;
    step("R9 idle");

    // random phase against the model
    for (int n = 0; n < 1500; n++) begin
      int p;
      logic [2:0] md;
      logic [7:0] dst;
      if ($urandom_range(3) == 0) begin
        p = $urandom_range(NP - 1);
        case ($urandom_range(4))
          0: md = 3'd0; 1: md = 3'd1; 2: md = 3'd2; 3: md = 3'd4; default: md = 3'd7;
        endcase
        case ($urandom_range(3))
          0: dst = 8'hFF; 1: dst = 8'($urandom_range(NU - 1)); default: dst = 8'($urandom);
        endcase
        ent[p] = mkEnt($urandom_range(3) == 0, 1'($urandom), 1'($urandom),
                       1'($urandom), md, dst, 8'($urandom));
      end
      if ($urandom_range(7) == 0) unitLog[$urandom_range(NU - 1)] = 8'($urandom);
      extVector = 8'($urandom);
      for (int b = 0; b < 3; b++)
        if ($urandom_range(1) == 0) begin
          int q;
          q = $urandom_range(NP - 1);
          pinIn[q] = ~pinIn[q];
        end
      step("R9 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule